// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Datapath

This block is the data side of a synchronous burst SRAM core. Each rising clock edge registers one command from the chip enable, the write controls, the address and the write data. The word is 18 bits wide and is split into two 9-bit byte lanes. A write can update selected lanes, or every lane through the global write. A read returns the addressed word on the read bus. A strap input chooses how the read data leaves the core. In flow-through mode the data comes straight from the array. In pipelined mode it passes through an output register, which adds one cycle.

The output drivers are modelled as a drive-enable flag next to the read bus. The bus counts as high-impedance whenever the flag is low. Output enable and sleep act on the drivers at once, with no clock. While sleep is high, commands are ignored but the array keeps its contents. A deselect switches the drivers off in the same slot where read data would have appeared, so no read slot is held one cycle longer. Burst address generation is not part of this block; every command carries its own address.

Top module: `ssram_datapath`

## Requirements
- R1: With `pipe_mode_i` low (flow-through), a read registered at edge j drives `rdata_o` with the addressed word, and sets `dq_oe_o` high, from edge j until edge j+1.
- R2: With `pipe_mode_i` high (pipelined), a read registered at edge j is presented from the output register between edges j+1 and j+2.
- R3: A deselect (`ce_i` low at an edge) ends the drive in its own slot. In flow-through mode the drivers go off right after the edge that registers the deselect. In pipelined mode they go off after the next edge. The drivers never stay on for an extra cycle.
- R4: A byte write (`ce_i`, `bwe_i` and at least one bit of `lane_we_i` high, `gwe_i` low) updates only the selected lanes. Lane 0 is bits 8:0 and lane 1 is bits 17:9. The other lane keeps its old value.
- R5: `bwe_i` high with no bit of `lane_we_i` set and `gwe_i` low is a read, not a write.
- R6: `gwe_i` high with `ce_i` high writes all 18 bits, whatever `bwe_i` and `lane_we_i` hold.
- R7: Write data is registered on the same edge as the write command. A read registered on the next edge returns the new word.
- R8: `oe_i` low forces `dq_oe_o` low within the same cycle, without a clock edge.
- R9: `sleep_i` high forces `dq_oe_o` low at once. Commands registered while it is high, including writes, have no effect. The stored data is kept. The first command after `sleep_i` falls is executed normally.
- R10: In the cycle after a write is registered, `dq_oe_o` is low, because the bus belongs to the writer.
- R11: While reset is applied and just after it, `dq_oe_o` is low and `rdata_o` is zero.
- R12: `rdata_o` is all zeros whenever `dq_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W (6) | Word address, registered each edge |
| ce_i | input | 1 | Chip enable; low is a deselect |
| bwe_i | input | 1 | Byte-write enable |
| lane_we_i | input | LANES (2) | Per-lane write selects |
| gwe_i | input | 1 | Global write, all lanes |
| wdata_i | input | 18 | Write data |
| pipe_mode_i | input | 1 | 0 = flow-through, 1 = pipelined |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous sleep |
| rdata_o | output | 18 | Read data, zero when not driven |
| dq_oe_o | output | 1 | Output driver enable |

## Verification
The assertions assume that `pipe_mode_i` is a strap that does not change during read traffic. The pipelined deselect property is only checked when the mode has held for two edges. They also assume that the synchronous controls settle away from the rising edge, so the values sampled at the edge are the ones that were registered. The bench drives every input on the falling edge. It changes the mode only between idle commands. It toggles `oe_i` and `sleep_i` in the middle of a cycle only inside a dedicated probe, which restores them before the next falling edge.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ssram_cmd_reg.sv
module ssram_cmd_reg
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              bwe_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic              gwe_i,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  mask_q,
  output logic [DATA_W-1:0] wdata_q
);
  op_e              op_d;
  logic [LANES-1:0] mask_d;
  logic             is_write;
  logic             load_en;

  // Decode: global write overrides lane selects; a byte write needs a lane.
  always_comb begin
    is_write = gwe_i | (bwe_i & (|lane_we_i));
    mask_d   = gwe_i ? {LANES{1'b1}} : lane_we_i;
    if (sleep_i || !ce_i) begin
      op_d = OP_IDLE;
    end else if (is_write) begin
      op_d = OP_WRITE;
    end else begin
      op_d = OP_READ;
    end
    load_en = (op_d != OP_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;
    end else begin
      op_q <= op_d;
    end
  end

  // Datapath registers: no reset, loaded only for a live command.
  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q  <= addr_i;
      mask_q  <= mask_d;
      wdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/ssram_lane_array.sv
module ssram_lane_array
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [LANES-1:0]  mask_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata
);
  logic [LANES-1:0] lane_we;

  always_comb begin
    lane_we = (op_q == OP_WRITE) ? mask_q : '0;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    // Self-timed write: completes on the edge after the command is registered.
    always_ff @(posedge clk) begin
      if (lane_we[l]) begin
        mem[addr_q] <= wdata_q[l*LANE_W +: LANE_W];
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[addr_q];
  end
endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage
  import ssram_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  input  op_e               op_q,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dq_oe_o
);
  logic              pipe_vld_q;
  logic              pipe_vld_d;
  logic [DATA_W-1:0] pipe_data_q;
  logic              pipe_load;
  logic              slot_valid;
  logic              bus_taken;
  logic [DATA_W-1:0] src_data;

  always_comb begin
    pipe_vld_d = (op_q == OP_READ);
    pipe_load  = (op_q == OP_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_vld_q <= 1'b0;
    end else begin
      pipe_vld_q <= pipe_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pipe_load) begin
      pipe_data_q <= arr_rdata;
    end
  end

  // Deselect and write both clear the slot flag at the stage that would carry data.
  always_comb begin
    slot_valid = pipe_mode_i ? pipe_vld_q : (op_q == OP_READ);
    bus_taken  = (op_q == OP_WRITE);
    src_data   = pipe_mode_i ? pipe_data_q : arr_rdata;
    dq_oe_o    = oe_i & ~sleep_i & slot_valid & ~bus_taken;
    rdata_o    = dq_oe_o ? src_data : '0;
  end
endmodule

// File: rtl/ssram_datapath.sv
module ssram_datapath
  import ssram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 2,
  parameter int LANE_W     = 9,
  parameter int RST_STAGES = 2,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_i,
  input  logic              bwe_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic              gwe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pipe_mode_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dq_oe_o
);
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  core_rst_n;
  op_e                   op_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [LANES-1:0]      mask_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [DATA_W-1:0]     arr_rdata;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[RST_STAGES-1];

  ssram_cmd_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cmd (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .ce_i      (ce_i),
    .bwe_i     (bwe_i),
    .lane_we_i (lane_we_i),
    .gwe_i     (gwe_i),
    .sleep_i   (sleep_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .mask_q    (mask_q),
    .wdata_q   (wdata_q)
  );

  ssram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .mask_q  (mask_q),
    .wdata_q (wdata_q),
    .rdata   (arr_rdata)
  );

  ssram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .pipe_mode_i (pipe_mode_i),
    .oe_i        (oe_i),
    .sleep_i     (sleep_i),
    .op_q        (op_q),
    .arr_rdata   (arr_rdata),
    .rdata_o     (rdata_o),
    .dq_oe_o     (dq_oe_o)
  );
endmodule

// File: rtl/ssram_datapath_chk.sv
module ssram_datapath_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_i,
  input logic              gwe_i,
  input logic              sleep_i,
  input logic              oe_i,
  input logic              pipe_mode_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              dq_oe_o
);
  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |-> !dq_oe_o);

  // R9
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !dq_oe_o);

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_o |-> (rdata_o == '0));

  // R3
  flow_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode_i && $past(!pipe_mode_i) && $past(!ce_i)) |-> !dq_oe_o);

  // R3
  pipe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode_i && $past(pipe_mode_i) && $past(!ce_i, 2)) |-> !dq_oe_o);

  // R10
  write_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_i && gwe_i && !sleep_i) |-> !dq_oe_o);
endmodule

bind ssram_datapath ssram_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ce_i        (ce_i),
  .gwe_i       (gwe_i),
  .sleep_i     (sleep_i),
  .oe_i        (oe_i),
  .pipe_mode_i (pipe_mode_i),
  .rdata_o     (rdata_o),
  .dq_oe_o     (dq_oe_o)
);

// File: tb/tb_ssram_datapath.sv
module tb_ssram_datapath;
  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          ce_i, bwe_i, gwe_i, pipe_mode_i, oe_i, sleep_i;
  logic [1:0]    lane_we_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          dq_oe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ssram_datapath dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_i(ce_i), .bwe_i(bwe_i),
    .lane_we_i(lane_we_i), .gwe_i(gwe_i), .wdata_i(wdata_i),
    .pipe_mode_i(pipe_mode_i), .oe_i(oe_i), .sleep_i(sleep_i),
    .rdata_o(rdata_o), .dq_oe_o(dq_oe_o)
  );

  typedef struct {
    logic          ce, bwe, gwe, sleep, oe;
    logic [1:0]    lanes;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            op;   // 0 idle, 1 read, 2 write
    logic [DW-1:0] rv;
  } cmd_t;

  logic [DW-1:0] model [64];
  cmd_t c1, c2;
  logic mode, cur_mode;
  logic [DW-1:0] obs_data;
  logic          obs_drv;

  function automatic logic [DW-1:0] pat(input int a);
    logic [5:0] x = a[5:0];
    return {x ^ 6'h2A, 3'b101, x, 3'b011};
  endfunction

  function automatic cmd_t mk(input logic ce, bwe, gwe, input logic [1:0] lanes,
                              input int a, input logic [DW-1:0] d,
                              input logic sl, input logic oe);
    cmd_t c;
    c.ce = ce; c.bwe = bwe; c.gwe = gwe; c.lanes = lanes; c.addr = a[AW-1:0];
    c.data = d; c.sleep = sl; c.oe = oe; c.rv = '0;
    if (sl || !ce) c.op = 0;
    else if (gwe || (bwe && lanes != 2'b00)) c.op = 2;
    else c.op = 1;
    return c;
  endfunction

  function automatic cmd_t idle();
    return mk(1'b0, 1'b0, 1'b0, 2'b00, 0, '0, 1'b0, 1'b1);
  endfunction

  function automatic cmd_t rd(input int a);
    return mk(1'b1, 1'b0, 1'b0, 2'b00, a, '0, 1'b0, 1'b1);
  endfunction

  function automatic cmd_t gw(input int a, input logic [DW-1:0] d);
    return mk(1'b1, 1'b0, 1'b1, 2'b00, a, d, 1'b0, 1'b1);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input cmd_t n);
    logic          exp_drv;
    logic [DW-1:0] exp_dat;
    int            slot_op;
    string         tag;
    @(negedge clk);
    if (c2.op == 2) begin
      logic [1:0] m = c2.gwe ? 2'b11 : c2.lanes;
      for (int l = 0; l < 2; l++)
        if (m[l]) model[c2.addr][l*9 +: 9] = c2.data[l*9 +: 9];
    end
    if (c1.op == 1) c1.rv = model[c1.addr];
    slot_op = cur_mode ? c2.op : c1.op;
    exp_drv = c1.oe && !c1.sleep && (c1.op != 2) && (slot_op == 1);
    exp_dat = cur_mode ? c2.rv : c1.rv;
    if (!c1.oe) tag = "R8";
    else if (c1.sleep) tag = "R9";
    else if (c1.op == 2) tag = "R10";
    else if (slot_op == 0) tag = "R3";
    else tag = cur_mode ? "R2" : "R1";
    check(dq_oe_o === exp_drv, tag, {17'd0, dq_oe_o}, {17'd0, exp_drv});
    if (exp_drv) check(rdata_o === exp_dat, cur_mode ? "R2" : "R1", rdata_o, exp_dat);
    else check(rdata_o === '0, "R12", rdata_o, '0);
    obs_data = rdata_o;
    obs_drv  = dq_oe_o;
    pipe_mode_i = mode;
    cur_mode    = mode;
    ce_i = n.ce; bwe_i = n.bwe; gwe_i = n.gwe; lane_we_i = n.lanes;
    addr_i = n.addr; wdata_i = n.data; sleep_i = n.sleep; oe_i = n.oe;
    c2 = c1;
    c1 = n;
  endtask

  task automatic expect_word(input string req, input logic [DW-1:0] exp);
    check(obs_drv === 1'b1 && obs_data === exp, req, obs_data, exp);
  endtask

  function automatic cmd_t rnd();
    int unsigned r = $urandom;
    logic ce  = (r % 10) < 8;
    logic gwe = ((r >> 4) % 5) == 0;
    logic bwe = (r >> 8) & 1;
    logic [1:0] ln = 2'((r >> 9) & 3);
    logic sl  = ((r >> 11) % 20) == 0;
    logic oe  = ((r >> 16) % 10) != 0;
    return mk(ce, bwe, gwe, ln, int'((r >> 20) % 64), DW'($urandom), sl, oe);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; ce_i = 0; bwe_i = 0; gwe_i = 0; lane_we_i = 0; addr_i = 0;
    wdata_i = 0; pipe_mode_i = 0; oe_i = 1; sleep_i = 0;
    mode = 1'b0; cur_mode = 1'b0;
    c1 = idle(); c2 = idle();
    obs_data = '0; obs_drv = 1'b0;
    repeat (4) @(negedge clk);
    // R11: reset holds the drivers off
    check(dq_oe_o === 1'b0, "R11", {17'd0, dq_oe_o}, '0);
    check(rdata_o === '0, "R11", rdata_o, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dq_oe_o === 1'b0 && rdata_o === '0, "R11", rdata_o, '0);

    // R6: fill the array with global writes (flow-through mode)
    for (int a = 0; a < 64; a++) step(gw(a, pat(a)));
    // R4: lane 0 only
    step(mk(1, 1, 0, 2'b01, 5, 18'h3FFFF, 0, 1)); step(rd(5)); step(idle());
    expect_word("R4", {pat(5)[17:9], 9'h1FF});
    // R4: lane 1 only
    step(mk(1, 1, 0, 2'b10, 6, 18'h00000, 0, 1)); step(rd(6)); step(idle());
    expect_word("R4", {9'h000, pat(6)[8:0]});
    // R5: byte-write enable with no lane is a read
    step(mk(1, 1, 0, 2'b00, 9, 18'h3FFFF, 0, 1)); step(idle());
    expect_word("R5", pat(9));
    // R6: global write overrides lane selects
    step(mk(1, 1, 1, 2'b01, 10, 18'h15555, 0, 1)); step(rd(10)); step(idle());
    expect_word("R6", 18'h15555);
    // R7: read right after write sees new word
    step(gw(11, 18'h2AAAA)); step(rd(11)); step(idle());
    expect_word("R7", 18'h2AAAA);
    // R9: write during sleep ignored, data kept
    step(mk(1, 0, 1, 2'b00, 12, 18'h00000, 1, 1)); step(mk(0, 0, 0, 0, 0, 0, 1, 1));
    step(rd(12)); step(idle());
    expect_word("R9", pat(12));
    // R9: first command after sleep accepted
    step(mk(0, 0, 0, 0, 0, 0, 1, 1)); step(gw(13, 18'h12345)); step(rd(13)); step(idle());
    expect_word("R9", 18'h12345);
    // R8 / R9: asynchronous probe on a flow-through read
    step(rd(14));
    @(posedge clk); #2;
    check(dq_oe_o === 1'b1 && rdata_o === pat(14), "R1", rdata_o, pat(14));
    oe_i = 1'b0; #1;
    check(dq_oe_o === 1'b0, "R8", {17'd0, dq_oe_o}, '0);
    oe_i = 1'b1; #1;
    check(dq_oe_o === 1'b1, "R8", {17'd0, dq_oe_o}, 18'd1);
    sleep_i = 1'b1; #1;
    check(dq_oe_o === 1'b0, "R9", {17'd0, dq_oe_o}, '0);
    sleep_i = 1'b0; #1;
    step(idle());

    // flow-through random traffic
    for (int i = 0; i < 1500; i++) step(rnd());
    step(idle()); step(idle());

    // R2: pipelined mode, one extra cycle
    mode = 1'b1;
    step(idle()); step(idle());
    step(gw(20, 18'h0BEEF)); step(rd(20)); step(idle()); step(idle());
    expect_word("R2", 18'h0BEEF);
    for (int i = 0; i < 1500; i++) step(rnd());
    step(idle()); step(idle()); step(idle());

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule